// File: doc/BRIEF.md
# Two-Domain Power Sequencing Controller

This block sits between software and an external power-management agent. It runs power-up and power-down requests for two dependent subsystems: a capture (input) subsystem and a compute (processing) subsystem. Software writes a control register for one subsystem to name the wanted power state. The controller checks that the change respects the cross-domain ordering rule. It then passes the request to the agent over a level request and acknowledge handshake, and records the state the agent reports in a status register.

The ordering rule has two halves. The compute subsystem may come up only while the capture subsystem is up. The capture subsystem may go down only once the compute subsystem is down. A request that breaks the rule is refused locally: it is not forwarded, and a sticky error and an interrupt are raised. Only one request may be with the agent at a time. A request that asks for the state a subsystem already has finishes at once without contacting the agent. A programmable cycle limit abandons a request that the agent never answers.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset every power state is off, status (address 2) reads 0, `agt_req` and `irq` are low, `wr_ready` is high and the timeout limit (address 3) reads the reset value 64.
- R2: An accepted write to address 0 (capture) or address 1 (compute) whose bit 0 differs from that subsystem's current state raises `agt_req` on the next clock edge. `agt_dom` is 0 for capture and 1 for compute, and `agt_tgt` equals bit 0.
- R3: A one-cycle `agt_ack` while a request is outstanding copies `agt_ack_on` into that subsystem's status bit (bit 0 capture on, bit 1 compute on), drops `agt_req` and clears busy on the same edge.
- R4: A compute power-up request while capture is off is not forwarded. It sets the sticky ordering error (status bit 3) and raises `irq`.
- R5: A capture power-down request while compute is on is not forwarded. It sets the ordering error (status bit 3) and raises `irq`.
- R6: A request for a subsystem's current state does not raise `agt_req`, sets no error and leaves the status unchanged.
- R7: While a request is outstanding, `wr_ready` is low, status bit 2 (busy) reads 1, and `agt_req`, `agt_dom` and `agt_tgt` hold steady. Writes are accepted only when `wr_ready` is high.
- R8: If no acknowledge arrives within the limit held at address 3, the request is dropped, the power state is left unchanged, the sticky timeout error (status bit 4) is set and `irq` rises.
- R9: Error bits stay set until software writes 1 to the matching bit of address 2. `irq` is high exactly while either error bit is set.
- R10: An `agt_ack` that arrives while no request is outstanding has no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_ready | output | 1 | Write accepted this cycle when high |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read data, one cycle after `rd_addr` |
| irq | output | 1 | Error interrupt, level |
| agt_req | output | 1 | Level request to the power agent |
| agt_dom | output | 1 | Subsystem of the request, 0 capture, 1 compute |
| agt_tgt | output | 1 | Requested state, 1 on |
| agt_ack | input | 1 | One-cycle completion from the agent |
| agt_ack_on | input | 1 | State reached, valid with `agt_ack` |

## Verification
The sequencing is driven through a legal bring-up (capture up, then compute up), a legal shutdown in reverse order, and both illegal orderings. Comparing these shows that refusal depends on the other subsystem's state and not on the direction alone. Repeat writes for the current state are set against real changes, which shows that the agent is contacted only when a change is needed. A request that is never answered, an acknowledge that arrives when nothing is outstanding, and a status read taken while busy separate the timeout, the filtering of stray acknowledges and the hold-off path from normal completion.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int ADDR_CAP  = 0;
  localparam int ADDR_CMP  = 1;
  localparam int ADDR_STAT = 2;
  localparam int ADDR_LIM  = 3;

  localparam int ST_CAP_ON = 0;
  localparam int ST_CMP_ON = 1;
  localparam int ST_BUSY   = 2;
  localparam int ST_ORDER  = 3;
  localparam int ST_TMO    = 4;

  typedef enum logic {DOM_CAP = 1'b0, DOM_CMP = 1'b1} dom_e;
endpackage

// File: rtl/pwr_order_chk.sv
module pwr_order_chk
  import pwr_seq_pkg::*;
(
  input  logic dom,
  input  logic tgt,
  input  logic cap_on,
  input  logic cmp_on,
  output logic same_state,
  output logic illegal
);
  logic cur;
  always_comb begin
    cur        = (dom == DOM_CMP) ? cmp_on : cap_on;
    same_state = (tgt == cur);
    illegal    = 1'b0;
    if (!same_state) begin
      if (dom == DOM_CMP && tgt && !cap_on) illegal = 1'b1;
      if (dom == DOM_CAP && !tgt && cmp_on) illegal = 1'b1;
    end
  end
endmodule

// File: rtl/pwr_agent_fsm.sv
module pwr_agent_fsm #(
  parameter int TO_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            st_dom,
  input  logic            st_tgt,
  input  logic [TO_W-1:0] limit,
  input  logic            agt_ack,
  input  logic            agt_ack_on,
  output logic            agt_req,
  output logic            agt_dom,
  output logic            agt_tgt,
  output logic            busy,
  output logic            cap_on,
  output logic            cmp_on,
  output logic            tmo_pulse
);
  logic [TO_W-1:0] cnt;
  logic            expire;

  assign busy   = agt_req;
  assign expire = agt_req && !agt_ack && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      agt_req   <= 1'b0;
      agt_dom   <= 1'b0;
      agt_tgt   <= 1'b0;
      cnt       <= '0;
      cap_on    <= 1'b0;
      cmp_on    <= 1'b0;
      tmo_pulse <= 1'b0;
    end else begin
      tmo_pulse <= 1'b0;
      if (agt_req) begin
        if (agt_ack) begin
          agt_req <= 1'b0;
          if (agt_dom) cmp_on <= agt_ack_on;
          else         cap_on <= agt_ack_on;
        end else if (expire) begin
          agt_req   <= 1'b0;
          tmo_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (start) begin
        agt_req <= 1'b1;
        agt_dom <= st_dom;
        agt_tgt <= st_tgt;
        cnt     <= '0;
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    agt_req && !agt_ack && !expire |=> agt_req && $stable(agt_dom) && $stable(agt_tgt));
  p_ack_done_r3: assert property (@(posedge clk) disable iff (rst)
    agt_req && agt_ack |=> !agt_req && ((agt_dom ? cmp_on : cap_on) == $past(agt_ack_on)));
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt <= limit);
  p_idle_ack_r10: assert property (@(posedge clk) disable iff (rst)
    !agt_req && agt_ack |=> $stable(cap_on) && $stable(cmp_on));
endmodule

// File: rtl/pwr_reg_if.sv
module pwr_reg_if
  import pwr_seq_pkg::*;
#(
  parameter int AW     = 2,
  parameter int DW     = 16,
  parameter int TO_W   = 12,
  parameter logic [TO_W-1:0] LIM_RST = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_acc,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  input  logic            set_order,
  input  logic            set_tmo,
  input  logic            cap_on,
  input  logic            cmp_on,
  input  logic            busy,
  output logic [TO_W-1:0] limit,
  output logic [DW-1:0]   rd_data,
  output logic            irq
);
  logic ord_err, tmo_err;
  logic clr_ord, clr_tmo;
  logic [DW-1:0] stat;

  assign clr_ord = wr_acc && (wr_addr == AW'(ADDR_STAT)) && wr_data[ST_ORDER];
  assign clr_tmo = wr_acc && (wr_addr == AW'(ADDR_STAT)) && wr_data[ST_TMO];
  assign irq     = ord_err | tmo_err;

  always_comb begin
    stat            = '0;
    stat[ST_CAP_ON] = cap_on;
    stat[ST_CMP_ON] = cmp_on;
    stat[ST_BUSY]   = busy;
    stat[ST_ORDER]  = ord_err;
    stat[ST_TMO]    = tmo_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ord_err <= 1'b0;
      tmo_err <= 1'b0;
      limit   <= LIM_RST;
      rd_data <= '0;
    end else begin
      if (set_order)    ord_err <= 1'b1;
      else if (clr_ord) ord_err <= 1'b0;
      if (set_tmo)      tmo_err <= 1'b1;
      else if (clr_tmo) tmo_err <= 1'b0;
      if (wr_acc && wr_addr == AW'(ADDR_LIM)) limit <= wr_data[TO_W-1:0];
      case (rd_addr)
        AW'(ADDR_STAT): rd_data <= stat;
        AW'(ADDR_LIM):  rd_data <= DW'(limit);
        AW'(ADDR_CAP):  rd_data <= DW'(cap_on);
        default:        rd_data <= DW'(cmp_on);
      endcase
    end
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    ord_err && !clr_ord |=> ord_err);
  p_sticky_tmo_r9: assert property (@(posedge clk) disable iff (rst)
    tmo_err && !clr_tmo |=> tmo_err);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int AW   = 2,
  parameter int DW   = 16,
  parameter int TO_W = 12,
  parameter logic [TO_W-1:0] LIM_RST = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          agt_req,
  output logic          agt_dom,
  output logic          agt_tgt,
  input  logic          agt_ack,
  input  logic          agt_ack_on
);
  logic wr_acc, ctl_wr, dom, same, illegal, start, set_order;
  logic busy, cap_on, cmp_on, tmo_pulse;
  logic [TO_W-1:0] limit;

  assign wr_ready  = !busy;
  assign wr_acc    = wr_en && wr_ready;
  assign dom       = (wr_addr == AW'(ADDR_CMP));
  assign ctl_wr    = wr_acc && ((wr_addr == AW'(ADDR_CAP)) || dom);
  assign start     = ctl_wr && !same && !illegal;
  assign set_order = ctl_wr && illegal;

  pwr_order_chk u_chk (
    .dom(dom), .tgt(wr_data[0]), .cap_on(cap_on), .cmp_on(cmp_on),
    .same_state(same), .illegal(illegal)
  );

  pwr_agent_fsm #(.TO_W(TO_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .st_dom(dom), .st_tgt(wr_data[0]),
    .limit(limit), .agt_ack(agt_ack), .agt_ack_on(agt_ack_on),
    .agt_req(agt_req), .agt_dom(agt_dom), .agt_tgt(agt_tgt), .busy(busy),
    .cap_on(cap_on), .cmp_on(cmp_on), .tmo_pulse(tmo_pulse)
  );

  pwr_reg_if #(.AW(AW), .DW(DW), .TO_W(TO_W), .LIM_RST(LIM_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_acc(wr_acc), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .set_order(set_order), .set_tmo(tmo_pulse),
    .cap_on(cap_on), .cmp_on(cmp_on), .busy(busy), .limit(limit),
    .rd_data(rd_data), .irq(irq)
  );

  p_order_up_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(agt_req) && agt_dom && agt_tgt |-> cap_on);
  p_order_dn_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(agt_req) && !agt_dom && !agt_tgt |-> !cmp_on);
  p_one_req_r7: assert property (@(posedge clk) disable iff (rst)
    agt_req |-> !wr_ready);
endmodule

// File: tb/sim_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_seq_ctrl;
  logic clk = 0, rst = 1;
  logic wr_en = 0, agt_ack = 0, agt_ack_on = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic wr_ready, irq, agt_req, agt_dom, agt_tgt;
  logic [15:0] rd_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_seq_ctrl u0 (.clk, .rst, .wr_en, .wr_addr, .wr_data, .wr_ready, .rd_addr,
    .rd_data, .irq, .agt_req, .agt_dom, .agt_tgt, .agt_ack, .agt_ack_on);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a;
    @(posedge clk); #1 d = rd_data;
  endtask

  task automatic ack(logic on);
    @(negedge clk); agt_ack = 1; agt_ack_on = on;
    @(posedge clk); #1 agt_ack = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2, d); check("R1 status", d, 0);
    rd(3, d); check("R1 limit", d, 64);
    check("R1 req", agt_req, 0); check("R1 irq", irq, 0); check("R1 ready", wr_ready, 1);
  endtask

  task automatic t_bad_up();
    logic [15:0] d;
    wr(1, 1);
    check("R4 no req", agt_req, 0);
    repeat (3) @(posedge clk); #1;
    rd(2, d); check("R4 order err", d, 16'h08); check("R4 irq", irq, 1);
    wr(2, 16'h08); #1;
    check("R9 irq clear", irq, 0);
    rd(2, d); check("R9 status clear", d, 0);
  endtask

  task automatic t_cap_up();
    logic [15:0] d;
    wr(0, 1);
    check("R2 req", agt_req, 1); check("R2 dom", agt_dom, 0); check("R2 tgt", agt_tgt, 1);
    check("R7 ready low", wr_ready, 0);
    rd(2, d); check("R7 busy", d, 16'h04);
    check("R7 req held", agt_req, 1);
    ack(1);
    check("R3 req drop", agt_req, 0); check("R3 ready", wr_ready, 1);
    rd(2, d); check("R3 cap on", d, 16'h01);
  endtask

  task automatic t_same();
    logic [15:0] d;
    wr(0, 1);
    check("R6 no req", agt_req, 0);
    rd(2, d); check("R6 status", d, 16'h01);
  endtask

  task automatic t_cmp_up();
    logic [15:0] d;
    wr(1, 1);
    check("R2 cmp req", agt_req, 1); check("R2 cmp dom", agt_dom, 1);
    ack(1);
    rd(2, d); check("R3 both on", d, 16'h03);
  endtask

  task automatic t_bad_down();
    logic [15:0] d;
    wr(0, 0);
    check("R5 no req", agt_req, 0);
    rd(2, d); check("R5 order err", d, 16'h0B); check("R5 irq", irq, 1);
    wr(2, 16'h08);
  endtask

  task automatic t_idle_ack();
    logic [15:0] d;
    ack(0);
    rd(2, d); check("R10 ignored", d, 16'h03);
  endtask

  task automatic t_timeout();
    logic [15:0] d;
    wr(3, 5);
    rd(3, d); check("R8 limit", d, 5);
    wr(1, 0);
    check("R8 req up", agt_req, 1); check("R8 tgt", agt_tgt, 0);
    repeat (3) @(posedge clk); #1;
    check("R8 still waiting", agt_req, 1);
    repeat (10) @(posedge clk); #1;
    check("R8 dropped", agt_req, 0);
    rd(2, d); check("R8 tmo err", d, 16'h13); check("R8 irq", irq, 1);
    wr(2, 16'h10); #1;
    check("R9 tmo clear", irq, 0);
  endtask

  task automatic t_shutdown();
    logic [15:0] d;
    wr(1, 0); ack(0);
    wr(0, 0);
    check("R5 legal down fwd", agt_req, 1);
    ack(0);
    rd(2, d); check("R5 all off", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1 rst = 0;
    t_reset(); t_bad_up(); t_cap_up(); t_same(); t_cmp_up();
    t_bad_down(); t_idle_ack(); t_timeout(); t_shutdown();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule